// File: doc/BRIEF.md
# Single-cycle integer processor core

This block is a small RISC-V processor that completes one instruction on every clock edge. It fetches from an instruction memory and reaches data through a separate port, so the two memories never compete for a cycle. Each instruction word is decoded into a control record. That record steers a register file, an ALU, an immediate builder, next-PC selection and result selection. All of this logic is combinational between the program counter and the register file.

The instruction set is a fixed integer subset:
- word loads and stores;
- the register-register and register-immediate arithmetic, logic, shift and set-less-than forms;
- equal and not-equal branches;
- both jumps;
- the two upper-immediate forms.

The data port is a plain bus. Address, write data and a write strobe leave the core, and read data returns in the same cycle. A RAM or a memory-mapped I/O block can be hung on it. The RAM starts without initial contents, so programs must build their data at run time.

There is no state machine in the usual sense. The only sequencing state is the PC. Each cycle the decoded instruction class selects one of three transitions for it:
- `sequential`: PC+4;
- `relative`: PC plus the B or J immediate;
- `indirect`: register plus immediate, with bit 0 cleared.

Top module: `rvc_core`

## Requirements
- R1: While reset is held, and in the first cycle after its release, the fetch address is 0. After that, exactly one instruction is completed on each rising clock edge.
- R2: Register forms add, sub, and, or, xor, sll, srl and slt write rd. Shifts use only the low 5 bits of rs2, srl fills with zeros, and slt compares as signed values and gives 1 or 0.
- R3: Immediate forms addi, andi, ori, xori, slti, slli and srli use the sign-extended 12-bit immediate. The shift amount comes from immediate bits 4:0.
- R4: lw and sw (funct3 = 010) use the byte address rs1 + sign-extended offset. sw raises the write strobe for that one cycle, driving the address and rs2. lw writes the returned word to rd.
- R5: beq (funct3 000) and bne (funct3 001) move the PC by the signed B immediate when taken, and to PC+4 otherwise. Backward offsets are included.
- R6: jal writes PC+4 to rd and moves the PC by the signed J immediate. Negative offsets are included.
- R7: jalr (funct3 000) jumps to rs1 + sign-extended immediate with bit 0 forced to 0, and writes PC+4 to rd. The target uses the value rs1 held before the write, even when rd equals rs1.
- R8: lui writes its 20-bit immediate to bits 31:12 of rd and zeros to bits 11:0.
- R9: auipc writes to rd the address of the auipc itself plus the 20-bit immediate shifted left by 12.
- R10: Register x0 always reads as zero. Any write aimed at it is dropped.
- R11: Any instruction outside the subset is a no-op that writes neither a register nor memory and advances the PC by 4. This covers other opcodes, other load/store widths, sltiu/sltu, srai/sra, and other branch conditions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at imem_addr, combinational |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data (rs2) |
| dmem_we | output | 1 | Store strobe, high for one cycle per sw |
| dmem_rdata | input | 32 | Load data at dmem_addr, combinational |

## Verification
The bench builds the core with its default reset address of 0. Attached to it are a 256-word instruction memory and a 4 KB data memory. The PC and the data address are therefore decoded over their low 10 and 12 bits.

The program lays out its results in 256-byte regions, one per requirement. Every register effect reaches the ports through a store into its region. Because the memories are small, the assembled test program can use negative branch and jump offsets, a jalr whose computed target is odd, and loads and stores with negative offsets.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int NREGS  = 1 << REG_AW;

    localparam logic [6:0] OPC_OP    = 7'b0110011;
    localparam logic [6:0] OPC_OPIMM = 7'b0010011;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [6:0] OPC_BR    = 7'b1100011;
    localparam logic [6:0] OPC_JAL   = 7'b1101111;
    localparam logic [6:0] OPC_JALR  = 7'b1100111;
    localparam logic [6:0] OPC_LUI   = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC = 7'b0010111;

    typedef enum logic [3:0] {
        K_NOP, K_ALU_R, K_ALU_I, K_LOAD, K_STORE, K_BRANCH, K_JAL, K_JALR, K_LUI, K_AUIPC
    } kind_e;

    typedef enum logic [2:0] {
        A_ADD, A_SUB, A_AND, A_OR, A_XOR, A_SLL, A_SRL, A_SLT
    } alu_op_e;

    typedef enum logic [2:0] { IMM_I, IMM_S, IMM_B, IMM_U, IMM_J } imm_e;

    typedef enum logic [1:0] { RES_ALU, RES_MEM, RES_LINK, RES_IMM } res_e;

    typedef struct packed {
        kind_e   kind;
        alu_op_e alu_op;
        imm_e    imm_sel;
        res_e    res_sel;
        logic    reg_we;
        logic    mem_we;
        logic    src_a_pc;
        logic    src_b_imm;
        logic    br_ne;
    } ctrl_t;
endpackage

// File: rtl/rvc_decode.sv
module rvc_decode
    import rvc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;

    assign opc = instr[6:0];
    assign f3  = instr[14:12];
    assign f7  = instr[31:25];

    function automatic alu_op_e op_of_f3(input logic [2:0] fn);
        unique case (fn)
            3'b001:  return A_SLL;
            3'b010:  return A_SLT;
            3'b100:  return A_XOR;
            3'b101:  return A_SRL;
            3'b110:  return A_OR;
            3'b111:  return A_AND;
            default: return A_ADD;
        endcase
    endfunction

    always_comb begin
        ctrl      = '0;
        ctrl.kind = K_NOP;
        unique case (opc)
            OPC_OP: if ((f7 == 7'h00 && f3 != 3'b011) || (f7 == 7'h20 && f3 == 3'b000)) begin
                ctrl.kind   = K_ALU_R;
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = f7[5] ? A_SUB : op_of_f3(f3);
            end
            OPC_OPIMM: if (f3 != 3'b011 && (f3 != 3'b001 || f7 == 7'h00)
                           && (f3 != 3'b101 || f7 == 7'h00)) begin
                ctrl.kind      = K_ALU_I;
                ctrl.reg_we    = 1'b1;
                ctrl.src_b_imm = 1'b1;
                ctrl.alu_op    = op_of_f3(f3);
            end
            OPC_LOAD: if (f3 == 3'b010) begin
                ctrl.kind      = K_LOAD;
                ctrl.reg_we    = 1'b1;
                ctrl.src_b_imm = 1'b1;
                ctrl.res_sel   = RES_MEM;
            end
            OPC_STORE: if (f3 == 3'b010) begin
                ctrl.kind      = K_STORE;
                ctrl.mem_we    = 1'b1;
                ctrl.src_b_imm = 1'b1;
                ctrl.imm_sel   = IMM_S;
            end
            OPC_BR: if (f3[2:1] == 2'b00) begin
                ctrl.kind    = K_BRANCH;
                ctrl.alu_op  = A_SUB;
                ctrl.imm_sel = IMM_B;
                ctrl.br_ne   = f3[0];
            end
            OPC_JAL: begin
                ctrl.kind    = K_JAL;
                ctrl.reg_we  = 1'b1;
                ctrl.imm_sel = IMM_J;
                ctrl.res_sel = RES_LINK;
            end
            OPC_JALR: if (f3 == 3'b000) begin
                ctrl.kind      = K_JALR;
                ctrl.reg_we    = 1'b1;
                ctrl.src_b_imm = 1'b1;
                ctrl.res_sel   = RES_LINK;
            end
            OPC_LUI: begin
                ctrl.kind    = K_LUI;
                ctrl.reg_we  = 1'b1;
                ctrl.imm_sel = IMM_U;
                ctrl.res_sel = RES_IMM;
            end
            OPC_AUIPC: begin
                ctrl.kind      = K_AUIPC;
                ctrl.reg_we    = 1'b1;
                ctrl.imm_sel   = IMM_U;
                ctrl.src_a_pc  = 1'b1;
                ctrl.src_b_imm = 1'b1;
            end
            default: ctrl.kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/rvc_imm.sv
module rvc_imm
    import rvc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    input  imm_e            sel,
    output logic [XLEN-1:0] imm
);
    always_comb begin
        unique case (sel)
            IMM_I:   imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
            IMM_S:   imm = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
            IMM_B:   imm = {{(XLEN-13){instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
            IMM_U:   imm = {instr[31:12], 12'b0};
            IMM_J:   imm = {{(XLEN-21){instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
            default: imm = '0;
        endcase
    end
endmodule

// File: rtl/rvc_alu.sv
module rvc_alu
    import rvc_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y
);
    localparam int SH_W = $clog2(XLEN);

    always_comb begin
        unique case (op)
            A_ADD:   y = a + b;
            A_SUB:   y = a - b;
            A_AND:   y = a & b;
            A_OR:    y = a | b;
            A_XOR:   y = a ^ b;
            A_SLL:   y = a << b[SH_W-1:0];
            A_SRL:   y = a >> b[SH_W-1:0];
            A_SLT:   y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/rvc_regfile.sv
module rvc_regfile
    import rvc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] ra1,
    input  logic [REG_AW-1:0] ra2,
    output logic [XLEN-1:0]   rd1,
    output logic [XLEN-1:0]   rd2,
    input  logic              we,
    input  logic [REG_AW-1:0] wa,
    input  logic [XLEN-1:0]   wd
);
    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NREGS; k++) regs[k] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    // R10: the zero register's storage never changes
    p_x0_zero_r10: assert property (@(posedge clk) disable iff (!rst_n) regs[0] == '0)
        else $error("x0 storage was written");
endmodule

// File: rtl/rvc_core.sv
module rvc_core
    import rvc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] pc, pc_next, pc_seq, pc_rel;
    logic [XLEN-1:0] rs1_val, rs2_val, imm, alu_a, alu_b, alu_y, result;
    logic            taken;
    ctrl_t           ctrl;

    rvc_decode u_dec (.instr(imem_data), .ctrl(ctrl));

    rvc_imm u_imm (.instr(imem_data), .sel(ctrl.imm_sel), .imm(imm));

    rvc_regfile u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra1(imem_data[19:15]), .ra2(imem_data[24:20]),
        .rd1(rs1_val), .rd2(rs2_val),
        .we(ctrl.reg_we), .wa(imem_data[11:7]), .wd(result)
    );

    assign alu_a = ctrl.src_a_pc  ? pc  : rs1_val;
    assign alu_b = ctrl.src_b_imm ? imm : rs2_val;

    rvc_alu u_alu (.a(alu_a), .b(alu_b), .op(ctrl.alu_op), .y(alu_y));

    assign pc_seq = pc + STEP;
    assign pc_rel = pc + imm;
    assign taken  = (ctrl.kind == K_BRANCH) && ((alu_y == '0) != ctrl.br_ne);

    // next-PC transition: sequential, relative or indirect
    always_comb begin
        if (ctrl.kind == K_JALR)
            pc_next = {alu_y[XLEN-1:1], 1'b0};
        else if (ctrl.kind == K_JAL || taken)
            pc_next = pc_rel;
        else
            pc_next = pc_seq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc <= RESET_PC;
        else        pc <= pc_next;
    end

    always_comb begin
        unique case (ctrl.res_sel)
            RES_MEM:  result = dmem_rdata;
            RES_LINK: result = pc_seq;
            RES_IMM:  result = imm;
            default:  result = alu_y;
        endcase
    end

    assign imem_addr  = pc;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rs2_val;
    assign dmem_we    = ctrl.mem_we;

    // R1: reset holds the PC at its start address
    p_reset_pc_r1: assert property (@(posedge clk) !rst_n |=> pc == RESET_PC)
        else $error("PC not at start address after reset");

    // R11: unsupported words step sequentially
    p_nop_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.kind == K_NOP |=> pc == $past(pc) + STEP)
        else $error("no-op did not advance PC by 4");

    // R5: untaken branch falls through
    p_br_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.kind == K_BRANCH && ((rs1_val == rs2_val) == ctrl.br_ne)) |=> pc == $past(pc) + STEP)
        else $error("untaken branch left sequence");

    // R7: indirect jump targets are even
    p_jalr_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.kind == K_JALR |=> pc[0] == 1'b0)
        else $error("jalr target bit 0 set");

    // R4: no store strobe outside a store
    p_store_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> imem_data[6:0] == OPC_STORE)
        else $error("store strobe on non-store");
endmodule

// File: tb/rvc_core_tb.sv
module rvc_core_tb;
    localparam int PERIOD = 10;
    localparam int ROM_W  = 256;
    localparam int RAM_W  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] rom [ROM_W];
    logic [31:0] dram [RAM_W];
    logic [31:0] ref_ram [RAM_W];
    logic [31:0] xr [32];
    logic [31:0] ref_pc;
    string       last_tag;
    int          n_run = 0, n_fail = 0, pw = 0;
    bit          done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    rvc_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_data  = rom[imem_addr[9:2]];
    assign dmem_rdata = dram[dmem_addr[11:2]];

    always @(posedge clk) if (dmem_we) dram[dmem_addr[11:2]] <= dmem_wdata;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string region_tag(input logic [31:0] a);
        case (a[11:8])
            4'h2: return "R2";   4'h3: return "R3";   4'h5: return "R5";
            4'h6: return "R6";   4'h7: return "R7";   4'h8: return "R8";
            4'h9: return "R9";   4'hA: return "R10";  4'hB: return "R11";
            default: return "R4";
        endcase
    endfunction

    // ---- encoders ----
    task automatic emit(input logic [31:0] w); rom[pw] = w; pw++; endtask
    task automatic op_i(input logic [2:0] f3, input logic [4:0] rd, input logic [4:0] rs1, input logic [31:0] im);
        emit({im[11:0], rs1, f3, rd, 7'h13});
    endtask
    task automatic op_r(input logic [6:0] f7, input logic [2:0] f3, input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2);
        emit({f7, rs2, rs1, f3, rd, 7'h33});
    endtask
    task automatic sw_(input logic [4:0] rs2, input logic [31:0] im, input logic [4:0] rs1);
        emit({im[11:5], rs2, rs1, 3'b010, im[4:0], 7'h23});
    endtask
    task automatic lw_(input logic [4:0] rd, input logic [31:0] im, input logic [4:0] rs1);
        emit({im[11:0], rs1, 3'b010, rd, 7'h03});
    endtask
    task automatic br_(input logic [2:0] f3, input logic [4:0] rs1, input logic [4:0] rs2, input logic [31:0] im);
        emit({im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'h63});
    endtask
    task automatic jal_(input logic [4:0] rd, input logic [31:0] im);
        emit({im[20], im[10:1], im[11], im[19:12], rd, 7'h6F});
    endtask
    task automatic jalr_(input logic [4:0] rd, input logic [4:0] rs1, input logic [31:0] im);
        emit({im[11:0], rs1, 3'b000, rd, 7'h67});
    endtask
    task automatic up_(input logic [6:0] opc, input logic [4:0] rd, input logic [19:0] im);
        emit({im, rd, opc});
    endtask

    function automatic logic [31:0] ref_alu(input logic [2:0] f3, input bit sub,
                                            input logic [31:0] a, input logic [31:0] b);
        case (f3)
            3'b000: return sub ? a - b : a + b;
            3'b001: return a << b[4:0];
            3'b010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'b100: return a ^ b;
            3'b101: return a >> b[4:0];
            3'b110: return a | b;
            default: return a & b;
        endcase
    endfunction

    task automatic wr(input logic [4:0] rd, input logic [31:0] v);
        if (rd != 5'd0) xr[rd] = v;
    endtask

    // compare ports against the model for this cycle, then advance the model
    task automatic check_and_step();
        logic [31:0] ins, a, b, ii, is, ib, ij, iu, npc, t;
        logic [6:0] opc, f7;
        logic [2:0] f3;
        logic [4:0] rd;
        string tag;
        bit is_sw;
        ins = rom[ref_pc[9:2]];
        opc = ins[6:0]; f3 = ins[14:12]; f7 = ins[31:25]; rd = ins[11:7];
        a = xr[ins[19:15]]; b = xr[ins[24:20]];
        ii = {{20{ins[31]}}, ins[31:20]};
        is = {{20{ins[31]}}, ins[31:25], ins[11:7]};
        ib = {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
        ij = {{11{ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
        iu = {ins[31:12], 12'b0};
        chk(imem_addr == ref_pc, last_tag, "pc", imem_addr, ref_pc);
        is_sw = (opc == 7'h23 && f3 == 3'b010);
        chk(dmem_we == is_sw, is_sw ? "R4" : "R11", "store strobe", {31'd0, dmem_we}, {31'd0, is_sw});
        if (is_sw && dmem_we) begin
            chk(dmem_addr == a + is, region_tag(a + is), "store addr", dmem_addr, a + is);
            chk(dmem_wdata == b, region_tag(a + is), "store data", dmem_wdata, b);
        end
        npc = ref_pc + 32'd4;
        tag = "R11";
        case (opc)
            7'h33: if ((f7 == 7'h00 && f3 != 3'b011) || (f7 == 7'h20 && f3 == 3'b000)) begin
                wr(rd, ref_alu(f3, f7[5], a, b)); tag = "R2";
            end
            7'h13: if (f3 != 3'b011 && (f3 != 3'b001 || f7 == 7'h00) && (f3 != 3'b101 || f7 == 7'h00)) begin
                wr(rd, ref_alu(f3, 1'b0, a, ii)); tag = "R3";
            end
            7'h03: if (f3 == 3'b010) begin
                t = a + ii; wr(rd, ref_ram[t[11:2]]); tag = "R4";
            end
            7'h23: if (f3 == 3'b010) begin
                t = a + is; ref_ram[t[11:2]] = b; tag = "R4";
            end
            7'h63: if (f3 == 3'b000 || f3 == 3'b001) begin
                if ((a == b) != f3[0]) npc = ref_pc + ib;
                tag = "R5";
            end
            7'h6F: begin wr(rd, ref_pc + 32'd4); npc = ref_pc + ij; tag = "R6"; end
            7'h67: if (f3 == 3'b000) begin
                t = (a + ii) & 32'hFFFF_FFFE; wr(rd, ref_pc + 32'd4); npc = t; tag = "R7";
            end
            7'h37: begin wr(rd, iu); tag = "R8"; end
            7'h17: begin wr(rd, ref_pc + iu); tag = "R9"; end
            default: tag = "R11";
        endcase
        if (rd == 5'd0 && tag inside {"R2", "R3", "R8"}) tag = "R10";
        ref_pc = npc;
        last_tag = tag;
    endtask

    task automatic build_program();
        // x31 = 0x800 base for high regions
        op_i(3'b000, 31, 0, 1024); op_r(7'h00, 3'b000, 31, 31, 31);
        // R3 immediate forms, stored at 0x300
        op_i(3'b000, 1, 0, -5);    op_i(3'b000, 2, 0, 7);
        op_i(3'b111, 3, 1, 32'h0F0); op_i(3'b110, 4, 2, -16);
        op_i(3'b100, 5, 1, 32'h555); op_i(3'b001, 6, 2, 28);
        op_i(3'b101, 7, 1, 4);     op_i(3'b010, 8, 1, 1);
        op_i(3'b010, 9, 2, -1);    op_i(3'b000, 11, 0, 32'h300);
        for (int k = 1; k <= 9; k++) sw_(5'(k), 32'((k - 1) * 4), 11);
        // R2 register forms, stored at 0x200
        op_i(3'b000, 10, 0, 32'h200);
        op_r(7'h00, 3'b000, 12, 1, 2); op_r(7'h20, 3'b000, 13, 2, 1);
        op_r(7'h00, 3'b111, 14, 1, 2); op_r(7'h00, 3'b110, 15, 1, 2);
        op_r(7'h00, 3'b100, 16, 1, 2); op_r(7'h00, 3'b001, 17, 2, 1);
        op_r(7'h00, 3'b101, 18, 1, 2); op_r(7'h00, 3'b010, 19, 1, 2);
        op_r(7'h00, 3'b010, 20, 2, 1);
        for (int k = 12; k <= 20; k++) sw_(5'(k), 32'((k - 12) * 4), 10);
        // R4 load/store with positive and negative offsets at 0x400
        op_i(3'b000, 21, 0, 32'h400); sw_(16, 0, 21); lw_(22, 0, 21);
        op_i(3'b000, 22, 22, 1); op_i(3'b000, 23, 21, 16);
        sw_(22, -8, 23); lw_(24, -8, 23); sw_(24, 12, 21);
        // R5 branches, stored at 0x500
        op_i(3'b000, 1, 0, 3); op_i(3'b000, 2, 0, 3); op_i(3'b000, 3, 0, 0);
        br_(3'b000, 1, 2, 8); op_i(3'b000, 3, 0, 1);
        br_(3'b001, 1, 2, 8); op_i(3'b000, 3, 3, 2);
        br_(3'b001, 1, 0, 8); op_i(3'b000, 3, 3, 64);
        op_i(3'b000, 4, 0, 0); op_i(3'b000, 5, 0, 4);
        op_i(3'b000, 4, 4, 1); br_(3'b001, 4, 5, -4);
        op_i(3'b000, 11, 31, -768); sw_(3, 0, 11); sw_(4, 4, 11);
        // R6 jal forward and backward, stored at 0x600
        jal_(14, 8); op_i(3'b000, 15, 0, 1);
        jal_(0, 8); jal_(0, 8); jal_(16, -4);
        op_i(3'b000, 11, 31, -512); sw_(14, 0, 11); sw_(15, 4, 11); sw_(16, 8, 11);
        // R7 jalr with odd target and rd == rs1, stored at 0x700
        up_(7'h17, 6, 0); jalr_(7, 6, 13); op_i(3'b000, 8, 0, 99); op_i(3'b000, 9, 0, 55);
        up_(7'h17, 12, 0); jalr_(12, 12, 12); op_i(3'b000, 13, 0, 77); op_i(3'b000, 17, 0, 5);
        op_i(3'b000, 11, 31, -256);
        sw_(7, 0, 11); sw_(8, 4, 11); sw_(9, 8, 11); sw_(12, 12, 11); sw_(13, 16, 11);
        // R8 lui, stored at 0x800
        up_(7'h37, 1, 20'hABCDE); up_(7'h37, 2, 20'h80000);
        sw_(1, 0, 31); sw_(2, 4, 31);
        // R9 auipc, stored at 0x900
        up_(7'h17, 3, 20'h0); up_(7'h17, 4, 20'h12345); up_(7'h17, 5, 20'hFFFFF);
        op_i(3'b000, 11, 31, 256); sw_(3, 0, 11); sw_(4, 4, 11); sw_(5, 8, 11);
        // R10 x0 behaviour, stored at 0xA00
        op_i(3'b000, 0, 0, 5); up_(7'h37, 0, 20'h12345); op_r(7'h00, 3'b000, 1, 0, 0);
        op_i(3'b000, 2, 0, 9); op_r(7'h00, 3'b000, 2, 2, 0);
        op_i(3'b000, 11, 31, 512); sw_(0, 0, 11); sw_(1, 4, 11); sw_(2, 8, 11);
        // R11 unsupported words, stored at 0xB00
        op_i(3'b000, 5, 0, 42);
        emit(32'h0000_0073); emit(32'hFFFF_FFFF);
        emit({12'd0, 5'd21, 3'b000, 5'd5, 7'h03});
        op_i(3'b011, 5, 5, 100);
        emit({7'h20, 5'd1, 5'd5, 3'b101, 5'd5, 7'h13});
        op_r(7'h20, 3'b101, 5, 5, 1);
        emit({7'd0, 5'd5, 5'd21, 3'b000, 5'd0, 7'h23});
        br_(3'b100, 0, 0, 8);
        op_i(3'b000, 11, 31, 768); sw_(5, 0, 11);
        jal_(0, 0);
    endtask

    initial begin
        for (int k = 0; k < ROM_W; k++) rom[k] = 32'h0000_0013;
        for (int k = 0; k < RAM_W; k++) begin dram[k] = '0; ref_ram[k] = '0; end
        for (int k = 0; k < 32; k++) xr[k] = '0;
        build_program();
        ref_pc = 32'h0;
        last_tag = "R1";
        repeat (3) @(negedge clk);
        chk(imem_addr == 32'h0, "R1", "pc in reset", imem_addr, 32'h0);
        chk(dmem_we == 1'b0, "R1", "strobe in reset", {31'd0, dmem_we}, 32'h0);
        rst_n = 1'b1;
        for (int c = 0; c < pw + 40; c++) begin
            check_and_step();
            @(negedge clk);
        end
        for (int k = 128; k < 768; k++)
            chk(dram[k] == ref_ram[k], region_tag(32'(k * 4)), "ram word", dram[k], ref_ram[k]);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule